// File: doc/BRIEF.md
# Interrupt Target Routing Register Bank

This block keeps, for every interrupt of a small distributor without affinity routing, an 8-bit mask naming the processor interfaces that may receive it. Software programs the masks over a simple 32-bit register bus with byte enables. Each request also carries the number of the CPU that issued it and a flag that says whether the access is secure. Four interrupts share one word, one byte each.

The block takes every interrupt's global pending and active state. For each interface it produces a registered pending vector. That vector shows an interrupt to an interface only when the interrupt is pending, not active, and the interface's bit is set in its mask. The first eight words cover the private interrupts 0 to 31. These words cannot be written, and a read of them returns the reader's own one-hot bit. Group membership and the non-secure access permissions come in as static inputs.

Top module: `irq_target_bank`

## Requirements
- R1: Interrupt m owns bits [8*(m mod 4)+7 : 8*(m mod 4)] of word m/4, and bit k of that byte selects interface k. All writable fields reset to zero.
- R2: Each of the four byte lanes is written only when its byte enable (req_be bit b for lane b) is set. The other lanes keep their value.
- R3: Words 0 to 7 ignore writes. Every byte read from them returns 1 << req_cpu, masked to the implemented interfaces.
- R4: A read request (req_valid=1, req_write=0) produces rd_valid=1 and rd_data on the next cycle. rd_valid is 0 in every cycle that does not follow a read request.
- R5: Words at index NUM_IRQ/4 and above read as zero and ignore writes. Mask bits at positions NUM_CPU and above read as zero and ignore writes.
- R6: For each interrupt m of 32 or more, iface_pend[c*NUM_IRQ+m] equals pending and not active and mask bit c, as sampled at the previous clock edge. Clearing a mask bit removes the indication from that interface one cycle after the write lands.
- R7: While an interrupt is active, no interface sees it as pending, whatever its mask. Once active clears, it is delivered again under the mask current at that time.
- R8: Private interrupts 0 to 31 that are pending and not active are shown to every implemented interface.
- R9: When sec_en=1, a non-secure access to the byte of an interrupt with irq_grp_sec=1 and irq_ns_ok=0 reads zero and leaves the byte unchanged. Secure accesses, and bytes with irq_ns_ok=1, behave normally.
- R10: With NUM_CPU=1, every read returns zero, writes have no effect, and every pending, non-active interrupt goes to interface 0.
- R11: If a mask write lands while the interrupt is pending, the first output cycle after the write uses the old mask and the following cycle uses the new one. The interrupt stays visible throughout on every interface present in both masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 8 | Word index within the bank |
| req_be | input | 4 | Byte-lane enables for writes |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 3 | Number of the CPU issuing the access |
| req_secure | input | 1 | Access is secure |
| sec_en | input | 1 | Security checks enabled |
| irq_grp_sec | input | NUM_IRQ | Interrupt is Group 0 or Secure Group 1 |
| irq_ns_ok | input | NUM_IRQ | Non-secure access to this interrupt's byte permitted |
| irq_pending | input | NUM_IRQ | Global pending state per interrupt |
| irq_active | input | NUM_IRQ | Global active state per interrupt |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| iface_pend | output | NUM_CPU*NUM_IRQ | Per-interface pending; bit c*NUM_IRQ+m |

## Verification
A mask write and the routing of the same interrupt can fall in one cycle. The bench issues a write that changes the target byte of interrupt 45 from interfaces {0,1} to {1} on the same clock edge that raises its pending input. It expects the old routing in the first output cycle and the new routing in the next, with interface 1 never losing the interrupt. Active-while-pending is also combined with retargeting: the mask changes while the interrupt is active, and on release the interrupt must reappear only under the new mask.

// File: rtl/irq_tgt_pkg.sv
package irq_tgt_pkg;
    localparam int LANES      = 4;
    localparam int PRIV_WORDS = 8;
    localparam int PRIV_IRQS  = 32;

    function automatic logic [7:0] cpu_bit(input logic [2:0] cpu);
        return 8'(1) << cpu;
    endfunction
endpackage

// File: rtl/irq_tgt_access.sv
module irq_tgt_access #(
    parameter int NUM_IRQ = 64
) (
    input  logic [7:0]         req_idx,
    input  logic               req_secure,
    input  logic               sec_en,
    input  logic [NUM_IRQ-1:0] irq_grp_sec,
    input  logic [NUM_IRQ-1:0] irq_ns_ok,
    output logic               idx_impl,
    output logic               idx_priv,
    output logic [3:0]         lane_ok
);
    import irq_tgt_pkg::*;
    localparam int ID_W = $clog2(NUM_IRQ);
    localparam logic [8:0] WORDS_V = 9'(NUM_IRQ / LANES);

    always_comb begin
        logic [ID_W-1:0] id;
        idx_impl = ({1'b0, req_idx} < WORDS_V);
        idx_priv = (req_idx < 8'(PRIV_WORDS));
        for (int b = 0; b < LANES; b++) begin
            id = ID_W'({req_idx, 2'(b)});
            lane_ok[b] = idx_impl &&
                         !(sec_en && !req_secure && irq_grp_sec[id] && !irq_ns_ok[id]);
        end
    end
endmodule

// File: rtl/irq_tgt_store.sv
module irq_tgt_store #(
    parameter int NUM_CPU = 4,
    parameter int NUM_IRQ = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_idx,
    input  logic [3:0]            wr_lane,
    input  logic [31:0]           wr_data,
    output logic [NUM_IRQ-33:0][7:0] spi_tgt
);
    import irq_tgt_pkg::*;
    localparam int NUM_SPI = NUM_IRQ - PRIV_IRQS;
    localparam int ID_W    = $clog2(NUM_IRQ);
    localparam int SPI_W   = $clog2(NUM_SPI);
    localparam logic [7:0] CPU_MASK = 8'((1 << NUM_CPU) - 1);

    typedef struct packed {
        logic [NUM_SPI-1:0][7:0] tgt;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        logic [ID_W-1:0] id;
        st_d = st_q;
        for (int b = 0; b < LANES; b++) begin
            id = ID_W'({wr_idx, 2'(b)});
            if (wr_en && wr_lane[b])
                st_d.tgt[SPI_W'(id - ID_W'(PRIV_IRQS))] = wr_data[8*b +: 8] & CPU_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign spi_tgt = st_q.tgt;

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(spi_tgt));
endmodule

// File: rtl/irq_tgt_read.sv
module irq_tgt_read #(
    parameter int NUM_CPU = 4,
    parameter int NUM_IRQ = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_req,
    input  logic [7:0]               req_idx,
    input  logic [2:0]               req_cpu,
    input  logic                     idx_impl,
    input  logic                     idx_priv,
    input  logic [3:0]               lane_ok,
    input  logic [NUM_IRQ-33:0][7:0] spi_tgt,
    output logic                     rd_valid,
    output logic [31:0]              rd_data
);
    import irq_tgt_pkg::*;
    localparam int NUM_SPI = NUM_IRQ - PRIV_IRQS;
    localparam int ID_W    = $clog2(NUM_IRQ);
    localparam int SPI_W   = $clog2(NUM_SPI);
    localparam logic [7:0] CPU_MASK = 8'((1 << NUM_CPU) - 1);

    typedef struct packed {
        logic        valid;
        logic [31:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        logic [ID_W-1:0] id;
        rd_d       = '0;
        rd_d.valid = rd_req;
        for (int b = 0; b < LANES; b++) begin
            id = ID_W'({req_idx, 2'(b)});
            if (rd_req && (NUM_CPU > 1) && idx_impl && lane_ok[b]) begin
                if (idx_priv) rd_d.data[8*b +: 8] = cpu_bit(req_cpu) & CPU_MASK;
                else          rd_d.data[8*b +: 8] = spi_tgt[SPI_W'(id - ID_W'(PRIV_IRQS))];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;

    a_r4_read_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    a_r4_no_unasked_data: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));
    a_r5_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !idx_impl) |=> (rd_data == 32'd0));
endmodule

// File: rtl/irq_tgt_route.sv
module irq_tgt_route #(
    parameter int NUM_CPU = 4,
    parameter int NUM_IRQ = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_IRQ-1:0]         irq_pending,
    input  logic [NUM_IRQ-1:0]         irq_active,
    input  logic [NUM_IRQ-33:0][7:0]   spi_tgt,
    output logic [NUM_CPU*NUM_IRQ-1:0] iface_pend
);
    import irq_tgt_pkg::*;
    localparam int NUM_SPI = NUM_IRQ - PRIV_IRQS;
    localparam int SPI_W   = $clog2(NUM_SPI);

    typedef struct packed {
        logic [NUM_CPU*NUM_IRQ-1:0] pend;
    } route_t;

    route_t rt_d, rt_q;

    always_comb begin
        logic [NUM_IRQ-1:0] eff;
        eff  = irq_pending & ~irq_active;
        rt_d = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int m = 0; m < PRIV_IRQS; m++)
                rt_d.pend[c*NUM_IRQ + m] = eff[m] && (c == 0 || NUM_CPU > 1);
            for (int m = PRIV_IRQS; m < NUM_IRQ; m++) begin
                if (NUM_CPU == 1)
                    rt_d.pend[c*NUM_IRQ + m] = eff[m];
                else
                    rt_d.pend[c*NUM_IRQ + m] = eff[m] &&
                        (|(spi_tgt[SPI_W'(m - PRIV_IRQS)] & cpu_bit(3'(c))));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    assign iface_pend = rt_q.pend;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
        a_r7_active_silent: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((iface_pend[c*NUM_IRQ +: NUM_IRQ] & $past(irq_active)) == '0));
        a_r6_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((iface_pend[c*NUM_IRQ +: NUM_IRQ] & ~$past(irq_pending)) == '0));
        a_r8_private_all: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (iface_pend[c*NUM_IRQ +: PRIV_IRQS] ==
                      $past(irq_pending[PRIV_IRQS-1:0] & ~irq_active[PRIV_IRQS-1:0])));
    end
endmodule

// File: rtl/irq_target_bank.sv
module irq_target_bank #(
    parameter int NUM_CPU = 4,
    parameter int NUM_IRQ = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [7:0]                 req_idx,
    input  logic [3:0]                 req_be,
    input  logic [31:0]                req_wdata,
    input  logic [2:0]                 req_cpu,
    input  logic                       req_secure,
    input  logic                       sec_en,
    input  logic [NUM_IRQ-1:0]         irq_grp_sec,
    input  logic [NUM_IRQ-1:0]         irq_ns_ok,
    input  logic [NUM_IRQ-1:0]         irq_pending,
    input  logic [NUM_IRQ-1:0]         irq_active,
    output logic                       rd_valid,
    output logic [31:0]                rd_data,
    output logic [NUM_CPU*NUM_IRQ-1:0] iface_pend
);
    import irq_tgt_pkg::*;

    logic                     idx_impl, idx_priv, wr_en;
    logic [3:0]               lane_ok;
    logic [NUM_IRQ-33:0][7:0] spi_tgt;

    irq_tgt_access #(.NUM_IRQ(NUM_IRQ)) u_access (
        .req_idx(req_idx), .req_secure(req_secure), .sec_en(sec_en),
        .irq_grp_sec(irq_grp_sec), .irq_ns_ok(irq_ns_ok),
        .idx_impl(idx_impl), .idx_priv(idx_priv), .lane_ok(lane_ok)
    );

    assign wr_en = req_valid && req_write && idx_impl && !idx_priv && (NUM_CPU > 1);

    irq_tgt_store #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(req_idx),
        .wr_lane(req_be & lane_ok), .wr_data(req_wdata), .spi_tgt(spi_tgt)
    );

    irq_tgt_read #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_read (
        .clk(clk), .rst_n(rst_n), .rd_req(req_valid && !req_write),
        .req_idx(req_idx), .req_cpu(req_cpu), .idx_impl(idx_impl),
        .idx_priv(idx_priv), .lane_ok(lane_ok), .spi_tgt(spi_tgt),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    irq_tgt_route #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_route (
        .clk(clk), .rst_n(rst_n), .irq_pending(irq_pending),
        .irq_active(irq_active), .spi_tgt(spi_tgt), .iface_pend(iface_pend)
    );

    a_r3_priv_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && idx_priv) |=> $stable(spi_tgt));

    if (NUM_CPU == 1) begin : g_solo
        a_r10_solo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
            rd_valid |-> (rd_data == 32'd0));
    end
endmodule

// File: tb/test_irq_target_bank.sv
`timescale 1ns/1ps
module test_irq_target_bank;
    localparam int NCPU = 4;
    localparam int NIRQ = 64;
    localparam int NW   = NIRQ / 4;

    logic clk = 0, rst_n = 0;
    always #10 clk = ~clk;

    logic req_valid = 0, req_write = 0, req_secure = 1, sec_en = 0;
    logic [7:0] req_idx = 0;
    logic [3:0] req_be = 0;
    logic [31:0] req_wdata = 0;
    logic [2:0] req_cpu = 0;
    logic [NIRQ-1:0] grp = 0, nsok = 0, pend = 0, act = 0;
    logic rd_valid, s_rd_valid;
    logic [31:0] rd_data, s_rd_data;
    logic [NCPU*NIRQ-1:0] out;
    logic [NIRQ-1:0] s_out;

    irq_target_bank #(.NUM_CPU(NCPU), .NUM_IRQ(NIRQ)) i_irq_target_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_idx(req_idx), .req_be(req_be), .req_wdata(req_wdata), .req_cpu(req_cpu),
        .req_secure(req_secure), .sec_en(sec_en), .irq_grp_sec(grp), .irq_ns_ok(nsok),
        .irq_pending(pend), .irq_active(act), .rd_valid(rd_valid), .rd_data(rd_data),
        .iface_pend(out));

    irq_target_bank #(.NUM_CPU(1), .NUM_IRQ(NIRQ)) i_irq_target_bank_solo (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_idx(req_idx), .req_be(req_be), .req_wdata(req_wdata), .req_cpu(req_cpu),
        .req_secure(req_secure), .sec_en(sec_en), .irq_grp_sec(grp), .irq_ns_ok(nsok),
        .irq_pending(pend), .irq_active(act), .rd_valid(s_rd_valid), .rd_data(s_rd_data),
        .iface_pend(s_out));

    int checks = 0, fails = 0;
    logic [7:0] sh [NIRQ];

    task automatic chk(input bit ok, input string tag, input logic [255:0] a, input logic [255:0] e);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
        end
    endtask

    function automatic bit blocked(input int id, input bit sec);
        return sec_en && !sec && grp[id] && !nsok[id];
    endfunction

    function automatic logic [31:0] exp_word(input int w, input int cpu, input bit sec);
        logic [31:0] r = 0;
        if (w >= NW) return 0;
        for (int b = 0; b < 4; b++) begin
            int id = w * 4 + b;
            if (blocked(id, sec)) continue;
            r[8*b +: 8] = (w < 8) ? ((8'd1 << cpu) & 8'h0F) : sh[id];
        end
        return r;
    endfunction

    function automatic logic [NCPU*NIRQ-1:0] exp_route();
        logic [NCPU*NIRQ-1:0] r = 0;
        for (int c = 0; c < NCPU; c++)
            for (int m = 0; m < NIRQ; m++)
                r[c*NIRQ + m] = pend[m] && !act[m] && (m < 32 || sh[m][c]);
        return r;
    endfunction

    task automatic bus_write(input int w, input logic [3:0] be, input logic [31:0] d,
                             input int cpu, input bit sec);
        req_valid = 1; req_write = 1; req_idx = 8'(w); req_be = be;
        req_wdata = d; req_cpu = 3'(cpu); req_secure = sec;
        for (int b = 0; b < 4; b++) begin
            int id = w * 4 + b;
            if (be[b] && w >= 8 && w < NW && !blocked(id, sec)) sh[id] = d[8*b +: 8] & 8'h0F;
        end
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic bus_read(input int w, input int cpu, input bit sec, input string tag);
        logic [31:0] e;
        e = exp_word(w, cpu, sec);
        req_valid = 1; req_write = 0; req_idx = 8'(w); req_cpu = 3'(cpu); req_secure = sec;
        @(negedge clk);
        req_valid = 0;
        chk(rd_valid && rd_data == e, tag, {rd_valid, rd_data}, {1'b1, e});
        chk(s_rd_valid && s_rd_data == 0, "R10 solo read zero", s_rd_data, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NIRQ; i++) sh[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rd_valid == 0 && out == 0, "R1 reset outputs", {rd_valid, out}, 0);
        bus_read(8, 0, 1, "R1 reset field zero");

        // R1/R3/R5 sweep: program every shared word, read every word from every CPU
        for (int w = 0; w < NW + 2; w++)
            bus_write(w, 4'hF, (32'(w) * 32'h25170B3) ^ 32'hC3A5_5AF0, (w % NCPU), 1);
        for (int w = 0; w < NW + 2; w++)
            for (int c = 0; c < NCPU; c++)
                bus_read(w, c, 1, "R1 R3 R5 sweep readback");

        // R2: partial byte enables
        bus_write(9, 4'b0101, 32'hFFFF_FFFF, 0, 1);
        bus_read(9, 1, 1, "R2 lane enables");
        bus_write(9, 4'b1010, 32'h0000_0000, 0, 1);
        bus_read(9, 2, 1, "R2 other lanes");

        // R3: banked word write ignored, reader bit returned
        bus_write(3, 4'hF, 32'hFFFF_FFFF, 2, 1);
        bus_read(3, 2, 1, "R3 banked reader bit");
        bus_read(3, 3, 1, "R3 banked reader bit cpu3");

        // R5: unimplemented word and interface bits
        bus_write(NW, 4'hF, 32'hFFFF_FFFF, 0, 1);
        bus_read(NW, 0, 1, "R5 unimplemented word");
        bus_write(10, 4'hF, 32'hF0F0_F0F0, 0, 1);
        bus_read(10, 0, 1, "R5 upper interface bits");

        // R4: read valid exactly one cycle, writes raise no valid
        req_valid = 1; req_write = 0; req_idx = 8'd12; req_cpu = 0;
        @(negedge clk); req_valid = 0;
        chk(rd_valid == 1, "R4 valid after read", rd_valid, 1);
        @(negedge clk);
        chk(rd_valid == 0, "R4 valid drops", rd_valid, 0);
        req_valid = 1; req_write = 1; req_be = 0;
        @(negedge clk); req_valid = 0; req_write = 0;
        chk(rd_valid == 0, "R4 no valid on write", rd_valid, 0);

        // R9: security filtering on word 10 (interrupts 40..43)
        bus_write(10, 4'hF, 32'h0506_0708, 0, 1);
        sec_en = 1; grp[41] = 1; grp[43] = 1; nsok[43] = 1;
        bus_read(10, 0, 0, "R9 nonsecure read masked");
        bus_write(10, 4'hF, 32'h0A0B_0C0D, 0, 0);
        bus_read(10, 0, 1, "R9 nonsecure write filtered");
        bus_read(10, 1, 0, "R9 nonsecure read after write");
        sec_en = 0;

        // R6/R7/R8/R10: routing sweep
        for (int k = 0; k < 24; k++) begin
            pend = {32'(k) * 32'h9E37_79B1, 32'(k + 3) * 32'h85EB_CA6B};
            act  = {pend[40:9], pend[63:32]} & {32'(k) * 32'h27D4_EB2F, 32'(k) * 32'h1656_67B1};
            @(negedge clk);
            chk(out == exp_route(), "R6 R7 R8 routing sweep", out, exp_route());
            chk(s_out == (pend & ~act), "R10 solo to interface 0", s_out, pend & ~act);
        end
        pend = 0; act = 0;

        // R11: retarget on the same edge the interrupt becomes pending
        bus_write(11, 4'b0010, 32'h0000_0300, 0, 1);
        pend[45] = 1;
        req_valid = 1; req_write = 1; req_idx = 8'd11; req_be = 4'b0010;
        req_wdata = 32'h0000_0200; req_secure = 1;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        chk(out[45] && out[NIRQ+45], "R11 old mask first", {out[45], out[NIRQ+45]}, 2'b11);
        sh[45] = 8'h02;
        @(negedge clk);
        chk(!out[45] && out[NIRQ+45], "R6 R11 removed interface drops",
            {out[45], out[NIRQ+45]}, 2'b01);

        // R7: active while pending, retarget, then release
        act[45] = 1;
        @(negedge clk);
        chk(out == exp_route() && !out[NIRQ+45], "R7 active hides", out, exp_route());
        bus_write(11, 4'b0010, 32'h0000_0400, 0, 1);
        act[45] = 0;
        @(negedge clk);
        chk(out[2*NIRQ+45] && !out[NIRQ+45] && out == exp_route(), "R7 release new mask",
            out, exp_route());

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule